// File: doc/BRIEF.md
# Zero-Crossing Tone Frequency Classifier

This block sorts telephone signalling tones by frequency. The signal has already been split into a low band and a high band and clipped to one bit per band. Because the signal keeps only its sign, the zero crossings are the only information left in it.

Each band has its own detector. On every sample strobe the detector watches for a rising sign change. It counts strobes from one rising crossing to the next, which gives the length of one full period in samples. It compares that length with four acceptance windows, one for each nominal tone of its band.

The low-band tones are 697, 770, 852 and 941 Hz. The high-band tones are 1209, 1336, 1477 and 1633 Hz. The sample strobe is the 3.579545 MHz reference divided by 64, about 55.93 kHz.

Each window is placed between two limits. The first is the accept limit, ±(1.5 % + 2 Hz) of nominal, which must still be recognised. The second is the reject limit, 3.5 %, which must be refused. A band reports a tone only after several consecutive periods agree, so single stray crossings produce no result.

Top module: `zc_tone_classifier`

## Requirements
- R1: While `rst` is high, and on the cycle after it, both valid flags and both hit vectors are 0. After reset, the first rising crossing of a band only starts a measurement and produces no period.
- R2: A rising crossing is a strobe sample with sign 1 whose previous strobe sample had sign 0. The period is the number of strobes from one rising-crossing sample up to and including the next. Sign changes on cycles without `smp_stb` have no effect.
- R3: Low-band windows in samples, inclusive, are: bit 0 = 697 Hz [78,82], bit 1 = 770 Hz [71,75], bit 2 = 852 Hz [64,67], bit 3 = 941 Hz [58,61].
- R4: High-band windows in samples, inclusive, are: bit 0 = 1209 Hz [45,47], bit 1 = 1336 Hz [41,43], bit 2 = 1477 Hz [37,39], bit 3 = 1633 Hz [33,35].
- R5: A band's valid flag rises on the strobe that completes the fourth consecutive period in the same window, and not earlier.
- R6: A period that falls in a different window clears valid on that strobe. That period then counts as the first of a new run of four. While valid stays high, the hit vector does not change.
- R7: A period that falls in no window clears valid on that strobe and discards the run.
- R8: A band whose last rising crossing lies 82 (low) or 47 (high) strobes back, with no further rising crossing, clears valid on that strobe. Its counter then holds.
- R9: The two bands operate independently. Activity on one band never changes the other band's outputs.
- R10: Outputs change only on cycles with `smp_stb` high. The hit vector is one-hot while valid is high and all zero while valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| low_sgn | input | 1 | Clipped low-band sign |
| high_sgn | input | 1 | Clipped high-band sign |
| low_hit | output | 4 | One-hot low-band tone, ascending frequency |
| low_valid | output | 1 | Low-band tone confirmed |
| high_hit | output | 4 | One-hot high-band tone, ascending frequency |
| high_valid | output | 1 | High-band tone confirmed |

## Verification
Each band has three pieces of internal state. A fault in any of them shows at the valid flag, at a predictable strobe.

- **Edge timer:** if it miscounts, a period at the edge of a window (78 vs 77, 47 vs 48) is judged on the wrong side. The error shows at the fifth rising crossing of a burst.
- **Run counter:** if it is wrong, valid rises one period too early or too late.
- **Stall timer:** if it is wrong, valid falls on the wrong strobe after the tone stops. That strobe is exactly 82 or 47 strobes after the last crossing.

Bursts that switch tone, and bursts with a gap, show whether a broken run is dropped on the same strobe.

// File: rtl/zc_tone_pkg.sv
package zc_tone_pkg;

    localparam int NUM_GROUPS      = 2;
    localparam int TONES_PER_GROUP = 4;

    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_CYCLE = 2'd1,
        EV_STALL = 2'd2
    } zc_ev_e;

    typedef struct packed {
        zc_ev_e                       kind;
        logic [TONES_PER_GROUP-1:0]   hits;
    } zc_meas_t;

    // nominal frequency, group 0 = low band, ascending within a group
    function automatic int nominal_hz(int grp, int idx);
        case (grp * TONES_PER_GROUP + idx)
            0: return 697;
            1: return 770;
            2: return 852;
            3: return 941;
            4: return 1209;
            5: return 1336;
            6: return 1477;
            default: return 1633;
        endcase
    endfunction

    function automatic longint sample_mhz(longint ref_hz, int div);
        return (ref_hz * 64'd1000) / longint'(div);
    endfunction

    // shortest accepted period: frequency edge at 1.025 f + 1 Hz, rounded
    function automatic int period_lo(longint fs_mhz, int f_hz);
        longint d;
        d = longint'(1025 * f_hz + 1000);
        return int'((2 * fs_mhz + d) / (2 * d));
    endfunction

    // longest accepted period: frequency edge at 0.975 f - 1 Hz, rounded
    function automatic int period_hi(longint fs_mhz, int f_hz);
        longint d;
        d = longint'(975 * f_hz - 1000);
        return int'((2 * fs_mhz + d) / (2 * d));
    endfunction

    function automatic int group_limit(longint fs_mhz, int grp);
        int m;
        m = 0;
        for (int k = 0; k < TONES_PER_GROUP; k++) begin
            if (period_hi(fs_mhz, nominal_hz(grp, k)) > m)
                m = period_hi(fs_mhz, nominal_hz(grp, k));
        end
        return m;
    endfunction

    function automatic int overall_limit(longint fs_mhz);
        int m;
        m = 0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (group_limit(fs_mhz, g) > m)
                m = group_limit(fs_mhz, g);
        end
        return m;
    endfunction

endpackage

// File: rtl/zc_edge_timer.sv
module zc_edge_timer
    import zc_tone_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int LIMIT = 82
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_i,
    input  logic             sgn_i,
    output zc_ev_e           kind_o,
    output logic [CNT_W-1:0] len_o
);

    logic             prev_q;
    logic             armed_q;
    logic [CNT_W-1:0] run_q;
    logic             rise;

    assign rise  = stb_i & sgn_i & ~prev_q;
    assign len_o = run_q;

    always_comb begin
        kind_o = EV_IDLE;
        if (rise && armed_q)
            kind_o = EV_CYCLE;
        else if (stb_i && armed_q && run_q == CNT_W'(LIMIT))
            kind_o = EV_STALL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            armed_q <= 1'b0;
            run_q   <= '0;
        end else if (stb_i) begin
            prev_q <= sgn_i;
            if (rise) begin
                armed_q <= 1'b1;
                run_q   <= CNT_W'(1);
            end else if (armed_q && run_q <= CNT_W'(LIMIT)) begin
                run_q <= run_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/zc_window_match.sv
module zc_window_match
    import zc_tone_pkg::*;
#(
    parameter int     CNT_W  = 7,
    parameter int     GRP    = 0,
    parameter longint FS_MHZ = 64'd55930390
) (
    input  zc_ev_e           kind_i,
    input  logic [CNT_W-1:0] len_i,
    output zc_meas_t         meas_o
);

    logic [TONES_PER_GROUP-1:0] in_win;

    for (genvar k = 0; k < TONES_PER_GROUP; k++) begin : g_win
        localparam int LO = period_lo(FS_MHZ, nominal_hz(GRP, k));
        localparam int HI = period_hi(FS_MHZ, nominal_hz(GRP, k));
        assign in_win[k] = (len_i >= CNT_W'(LO)) && (len_i <= CNT_W'(HI));
    end

    assign meas_o.kind = kind_i;
    assign meas_o.hits = (kind_i == EV_CYCLE) ? in_win : '0;

endmodule

// File: rtl/zc_persist.sv
module zc_persist
    import zc_tone_pkg::*;
#(
    parameter int CONFIRM = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  zc_meas_t                   meas_i,
    output logic [TONES_PER_GROUP-1:0] tone_o,
    output logic                       valid_o
);

    localparam int STK_W = $clog2(CONFIRM + 1);

    logic [TONES_PER_GROUP-1:0] cand_q, cand_n;
    logic [STK_W-1:0]           streak_q, streak_n;
    logic                       present_q;
    logic                       upd;

    always_comb begin
        cand_n   = cand_q;
        streak_n = streak_q;
        upd      = 1'b0;
        case (meas_i.kind)
            EV_CYCLE: begin
                upd = 1'b1;
                if (|meas_i.hits) begin
                    if (meas_i.hits == cand_q && streak_q != '0) begin
                        if (streak_q != STK_W'(CONFIRM))
                            streak_n = streak_q + STK_W'(1);
                    end else begin
                        cand_n   = meas_i.hits;
                        streak_n = STK_W'(1);
                    end
                end else begin
                    cand_n   = '0;
                    streak_n = '0;
                end
            end
            EV_STALL: begin
                upd      = 1'b1;
                cand_n   = '0;
                streak_n = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q    <= '0;
            streak_q  <= '0;
            present_q <= 1'b0;
        end else begin
            cand_q   <= cand_n;
            streak_q <= streak_n;
            if (upd)
                present_q <= (streak_n == STK_W'(CONFIRM));
        end
    end

    assign valid_o = present_q;
    assign tone_o  = present_q ? cand_q : '0;

endmodule

// File: rtl/zc_group.sv
module zc_group
    import zc_tone_pkg::*;
#(
    parameter int     CNT_W   = 7,
    parameter int     GRP     = 0,
    parameter longint FS_MHZ  = 64'd55930390,
    parameter int     CONFIRM = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stb_i,
    input  logic                       sgn_i,
    output logic [TONES_PER_GROUP-1:0] tone_o,
    output logic                       valid_o
);

    localparam int LIMIT = group_limit(FS_MHZ, GRP);

    zc_ev_e           kind;
    logic [CNT_W-1:0] len;
    zc_meas_t         meas;

    zc_edge_timer #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .stb_i  (stb_i),
        .sgn_i  (sgn_i),
        .kind_o (kind),
        .len_o  (len)
    );

    zc_window_match #(.CNT_W(CNT_W), .GRP(GRP), .FS_MHZ(FS_MHZ)) u_match (
        .kind_i (kind),
        .len_i  (len),
        .meas_o (meas)
    );

    zc_persist #(.CONFIRM(CONFIRM)) u_persist (
        .clk     (clk),
        .rst     (rst),
        .meas_i  (meas),
        .tone_o  (tone_o),
        .valid_o (valid_o)
    );

endmodule

// File: rtl/zc_tone_classifier.sv
module zc_tone_classifier
    import zc_tone_pkg::*;
#(
    parameter longint REF_HZ     = 64'd3579545,
    parameter int     SAMPLE_DIV = 64,
    parameter int     CONFIRM    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_stb,
    input  logic                       low_sgn,
    input  logic                       high_sgn,
    output logic [TONES_PER_GROUP-1:0] low_hit,
    output logic                       low_valid,
    output logic [TONES_PER_GROUP-1:0] high_hit,
    output logic                       high_valid
);

    localparam longint FS_MHZ = sample_mhz(REF_HZ, SAMPLE_DIV);
    localparam int     CNT_W  = $clog2(overall_limit(FS_MHZ) + 2);

    logic [NUM_GROUPS-1:0]                      sgn_v;
    logic [NUM_GROUPS-1:0][TONES_PER_GROUP-1:0] hit_v;
    logic [NUM_GROUPS-1:0]                      valid_v;

    assign sgn_v = {high_sgn, low_sgn};

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_band
        zc_group #(
            .CNT_W   (CNT_W),
            .GRP     (g),
            .FS_MHZ  (FS_MHZ),
            .CONFIRM (CONFIRM)
        ) u_group (
            .clk     (clk),
            .rst     (rst),
            .stb_i   (smp_stb),
            .sgn_i   (sgn_v[g]),
            .tone_o  (hit_v[g]),
            .valid_o (valid_v[g])
        );
    end

    assign low_hit    = hit_v[0];
    assign low_valid  = valid_v[0];
    assign high_hit   = hit_v[1];
    assign high_valid = valid_v[1];

endmodule

// File: rtl/zc_tone_classifier_chk.sv
module zc_tone_classifier_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_stb,
    input logic [3:0] low_hit,
    input logic       low_valid,
    input logic [3:0] high_hit,
    input logic       high_valid
);

    // R1
    low_reset_chk: assert property (@(posedge clk)
        rst |=> (!low_valid && low_hit == 4'b0));

    // R1
    high_reset_chk: assert property (@(posedge clk)
        rst |=> (!high_valid && high_hit == 4'b0));

    // R10
    low_shape_chk: assert property (@(posedge clk) disable iff (rst)
        low_valid |-> $countones(low_hit) == 1);

    // R10
    high_shape_chk: assert property (@(posedge clk) disable iff (rst)
        high_valid |-> $countones(high_hit) == 1);

    // R10
    low_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(low_valid) && $stable(low_hit)));

    // R10
    high_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(high_valid) && $stable(high_hit)));

    // R6
    low_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (low_valid && $past(low_valid)) |-> low_hit == $past(low_hit));

    // R6
    high_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (high_valid && $past(high_valid)) |-> high_hit == $past(high_hit));

endmodule

bind zc_tone_classifier zc_tone_classifier_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_stb    (smp_stb),
    .low_hit    (low_hit),
    .low_valid  (low_valid),
    .high_hit   (high_hit),
    .high_valid (high_valid)
);

// File: tb/sim_zc_tone_classifier.sv
module sim_zc_tone_classifier;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;

    // group, period in samples, measured periods, expected hit, expected valid
    localparam int VT [NV][5] = '{
        '{0, 80, 4, 1, 1}, '{0, 78, 4, 1, 1}, '{0, 82, 4, 1, 1},
        '{0, 77, 4, 0, 0}, '{0, 83, 4, 0, 0}, '{0, 72, 4, 2, 1},
        '{0, 71, 4, 2, 1}, '{0, 75, 4, 2, 1}, '{0, 70, 4, 0, 0},
        '{0, 66, 4, 4, 1}, '{0, 64, 4, 4, 1}, '{0, 67, 4, 4, 1},
        '{0, 60, 4, 8, 1}, '{0, 58, 4, 8, 1}, '{0, 61, 4, 8, 1},
        '{0, 62, 4, 0, 0}, '{0, 80, 3, 0, 0}, '{1, 46, 4, 1, 1},
        '{1, 45, 4, 1, 1}, '{1, 47, 4, 1, 1}, '{1, 48, 4, 0, 0},
        '{1, 44, 4, 0, 0}, '{1, 42, 4, 2, 1}, '{1, 38, 4, 4, 1},
        '{1, 34, 4, 8, 1}, '{1, 33, 4, 8, 1}, '{1, 35, 4, 8, 1},
        '{1, 36, 4, 0, 0}, '{1, 32, 4, 0, 0}, '{1, 40, 3, 0, 0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_stb = 1'b0;
    logic       low_sgn = 1'b0;
    logic       high_sgn = 1'b0;
    logic [3:0] low_hit, high_hit;
    logic       low_valid, high_valid;

    int  n_chk = 0;
    int  n_bad = 0;
    int  ph_l = 0;
    int  ph_h = 0;
    bit  glitch = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    zc_tone_classifier u0 (
        .clk        (clk),
        .rst        (rst),
        .smp_stb    (smp_stb),
        .low_sgn    (low_sgn),
        .high_sgn   (high_sgn),
        .low_hit    (low_hit),
        .low_valid  (low_valid),
        .high_hit   (high_hit),
        .high_valid (high_valid)
    );

    task automatic check(string req, string what, logic [3:0] ah, logic av,
                         logic [3:0] eh, logic ev);
        n_chk++;
        if (ah !== eh || av !== ev) begin
            n_bad++;
            $display("FAIL %s %s: actual hit=%b valid=%b expected hit=%b valid=%b",
                     req, what, ah, av, eh, ev);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_stb = 1'b0; low_sgn = 1'b0; high_sgn = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        ph_l = 0; ph_h = 0;
    endtask

    task automatic do_sample(bit l, bit h);
        @(negedge clk);
        smp_stb = 1'b1; low_sgn = l; high_sgn = h;
        @(negedge clk);
        smp_stb = 1'b0;
        if (glitch) begin
            low_sgn = ~l; high_sgn = ~h;
        end
        @(negedge clk);
        low_sgn = l; high_sgn = h;
        @(negedge clk);
    endtask

    // square waves; phase 0 is the rising sample; period 0 holds the sign low
    task automatic run_tones(int pl, int phh, int n);
        for (int i = 0; i < n; i++) begin
            bit l, h;
            l = (pl > 0) && (ph_l < pl / 2);
            h = (phh > 0) && (ph_h < phh / 2);
            do_sample(l, h);
            if (pl > 0) ph_l = (ph_l + 1) % pl;
            if (phh > 0) ph_h = (ph_h + 1) % phh;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog: actual run still busy expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", "during reset low", low_hit, low_valid, 4'b0, 1'b0);
        check("R1", "during reset high", high_hit, high_valid, 4'b0, 1'b0);

        // table walk: R3, R4, R5, R9
        for (int v = 0; v < NV; v++) begin
            int g, p, np;
            logic [3:0] eh;
            logic ev;
            string rq;
            g  = VT[v][0];
            p  = VT[v][1];
            np = VT[v][2];
            eh = 4'(VT[v][3]);
            ev = (VT[v][4] != 0);
            rq = (np < 4) ? "R5" : ((g == 0) ? "R3" : "R4");
            do_reset();
            if (g == 0) begin
                run_tones(p, 0, np * p + 1);
                check(rq, $sformatf("low period %0d", p), low_hit, low_valid, eh, ev);
                check("R9", "high idle", high_hit, high_valid, 4'b0, 1'b0);
            end else begin
                run_tones(0, p, np * p + 1);
                check(rq, $sformatf("high period %0d", p), high_hit, high_valid, eh, ev);
                check("R9", "low idle", low_hit, low_valid, 4'b0, 1'b0);
            end
        end

        // R1: first crossing only arms; 4 rises = 3 periods
        do_reset();
        check("R1", "after reset", low_hit, low_valid, 4'b0, 1'b0);
        run_tones(80, 0, 3 * 80 + 1);
        check("R1", "first rise arms only", low_hit, low_valid, 4'b0, 1'b0);
        run_tones(80, 0, 80);
        check("R5", "fourth period confirms", low_hit, low_valid, 4'b0001, 1'b1);

        // R6: switch tone; drop at once, confirm after four new periods
        run_tones(60, 0, 60);
        check("R6", "switch drops valid", low_hit, low_valid, 4'b0, 1'b0);
        run_tones(60, 0, 120);
        check("R6", "three of new tone", low_hit, low_valid, 4'b0, 1'b0);
        run_tones(60, 0, 60);
        check("R6", "new tone confirmed", low_hit, low_valid, 4'b1000, 1'b1);

        // R7: out-of-window period
        run_tones(70, 0, 70);
        check("R7", "gap period drops", low_hit, low_valid, 4'b0, 1'b0);

        // R8: stall timing, low band
        do_reset();
        run_tones(80, 0, 4 * 80 + 1);
        run_tones(0, 0, 81);
        check("R8", "low still valid at 81", low_hit, low_valid, 4'b0001, 1'b1);
        run_tones(0, 0, 1);
        check("R8", "low cleared at 82", low_hit, low_valid, 4'b0, 1'b0);

        // R8: stall timing, high band
        do_reset();
        run_tones(0, 46, 4 * 46 + 1);
        run_tones(0, 0, 46);
        check("R8", "high still valid at 46", high_hit, high_valid, 4'b0001, 1'b1);
        run_tones(0, 0, 1);
        check("R8", "high cleared at 47", high_hit, high_valid, 4'b0, 1'b0);

        // R9: both bands together, then high stops
        do_reset();
        run_tones(80, 42, 4 * 80 + 1);
        check("R9", "dual low", low_hit, low_valid, 4'b0001, 1'b1);
        check("R9", "dual high", high_hit, high_valid, 4'b0010, 1'b1);
        run_tones(80, 0, 60);
        check("R9", "high stopped", high_hit, high_valid, 4'b0, 1'b0);
        check("R9", "low unaffected", low_hit, low_valid, 4'b0001, 1'b1);

        // R2: sign flips between strobes are ignored
        do_reset();
        glitch = 1'b1;
        run_tones(80, 0, 4 * 80 + 1);
        glitch = 1'b0;
        check("R2", "glitches off-strobe", low_hit, low_valid, 4'b0001, 1'b1);

        // R10: no strobe, outputs hold
        repeat (20) @(negedge clk) low_sgn = ~low_sgn;
        check("R10", "hold without strobe", low_hit, low_valid, 4'b0001, 1'b1);

        // R1: reset clears a confirmed tone
        do_reset();
        check("R1", "reset clears", low_hit, low_valid, 4'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule